// File: doc/BRIEF.md
# JTAG Test Access Port with Auxiliary Controller Hand-Off

This block is the test access port controller that sits behind the four scan pins. It runs the 16-state TAP state machine. It holds a 5-bit instruction register, a one-bit bypass path and a 32-bit identification register. It can also lend the whole pin set to one of three auxiliary TAP controllers elsewhere on the chip.

Scanning one of three access opcodes into the instruction register hands the pins to the matching auxiliary. From then on, TMS and TDI are forwarded to that auxiliary, and its TDO and output enable drive the pins. The two auxiliaries that do not own the port see TMS and TDI held low, so they rest in Run-Test/Idle.

While an auxiliary owns the port, the main state machine keeps following TMS. It takes the port back when Update-DR is entered at the end of a data scan that passed through Pause-DR. A plain data scan without a pause leaves the auxiliary in control. Test-Logic-Reset, reached either through TMS or through the asynchronous reset pin, always gives the port back to the main controller.

Top module: `jtag_aux_tap`

## Requirements
- R1: The controller follows the standard 16-state TAP diagram, and five consecutive TCK rising edges with TMS high reach Test-Logic-Reset from any state.
- R2: While trst_n is low or the state is Test-Logic-Reset, the main controller owns the port, the instruction is IDCODE (5'b00001) and tdo_en is low.
- R3: In Capture-IR the instruction shift register loads 5'b00001. It shifts toward TDO least significant bit first, and the new instruction takes effect on leaving Update-IR.
- R4: BYPASS (5'b11111), and every opcode other than IDCODE and the three access opcodes, selects a one-bit register. That register captures 0 and then delays TDI by exactly one TCK.
- R5: IDCODE selects a 32-bit register that captures the IDCODE_VALUE parameter (bit 0 is 1) and shifts it out least significant bit first.
- R6: While the main controller owns the port, tdo and tdo_en change only on the falling edge of TCK. tdo_en is high only in Shift-IR or Shift-DR, and tdo is low whenever tdo_en is low.
- R7: Leaving Update-IR with 5'b00011, 5'b00100 or 5'b00101 in the shift register hands the port to auxiliary 0, 1 or 2 respectively, starting with the next TCK period. Until then all aux_tms and aux_tdi bits are low.
- R8: While auxiliary k owns the port, aux_tms[k] follows tms, aux_tdi[k] follows tdi, and tdo and tdo_en equal aux_tdo[k] and aux_tdo_en[k]. The other aux_tms and aux_tdi bits stay low.
- R9: On entering Update-DR, ownership returns to the main controller if Pause-DR was visited since the last Capture-DR. Otherwise the auxiliary keeps the port.
- R10: While an auxiliary owns the port, scans leave the main instruction and data registers unchanged, and passing Update-IR never changes ownership.
- R11: Entering Test-Logic-Reset through TMS, or asserting trst_n low, returns ownership to the main controller at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select from the pin |
| tdi | input | 1 | Test data in from the pin |
| tdo | output | 1 | Test data out toward the pin |
| tdo_en | output | 1 | Drive enable for the TDO pin (low means high impedance) |
| aux_tms | output | 3 | TMS forwarded to each auxiliary, low when not owner |
| aux_tdi | output | 3 | TDI forwarded to each auxiliary, low when not owner |
| aux_tdo | input | 3 | TDO returned by each auxiliary |
| aux_tdo_en | input | 3 | Output enable returned by each auxiliary |

## Verification
The assertions rely on three assumptions about the environment:
- TMS and TDI change only away from the rising TCK edge.
- trst_n is released between edges.
- The auxiliaries drive aux_tdo and aux_tdo_en on the falling edge, as any TAP does.

The bench respects all three. It drives tms, tdi and trst_n one nanosecond after a rising edge, samples just after the falling edge, and uses auxiliary stubs that update their returns only on the falling edge of TCK.

Ownership is handed over only with a Run-Test/Idle step after Update-IR, so the auxiliary and the main state machine stay in step. With that, the Pause-DR return sequence seen by the main machine matches what the auxiliary sees.

// File: rtl/jtag_aux_tap.sv
`timescale 1ns/1ps
module jtag_aux_tap #(
  parameter logic [31:0] IDCODE_VALUE = 32'h4B6A_D0E5
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  input  logic       tdi,
  output logic       tdo,
  output logic       tdo_en,
  output logic [2:0] aux_tms,
  output logic [2:0] aux_tdi,
  input  logic [2:0] aux_tdo,
  input  logic [2:0] aux_tdo_en
);

  typedef enum logic [3:0] {
    EX2DR = 4'h0, EX1DR = 4'h1, SHDR = 4'h2, PSDR = 4'h3,
    SELIR = 4'h4, UPDR  = 4'h5, CAPDR = 4'h6, SELDR = 4'h7,
    EX2IR = 4'h8, EX1IR = 4'h9, SHIR = 4'hA, PSIR = 4'hB,
    RTI   = 4'hC, UPIR  = 4'hD, CAPIR = 4'hE, TLR  = 4'hF
  } tap_e;

  localparam logic [4:0] OP_IDCODE = 5'b00001;
  localparam logic [4:0] OP_AUX0   = 5'b00011;
  localparam logic [4:0] OP_AUX2   = 5'b00101;

  tap_e        st, nxt;
  logic [4:0]  ir_q, ir_sr;
  logic        bp_q;
  logic [31:0] id_sr;
  logic [1:0]  owner;
  logic        paused;
  logic        tdo_q, en_q;
  logic        grant_ok;
  logic [4:0]  grant_off;

  always_comb begin
    case (st)
      TLR:   nxt = tms ? TLR   : RTI;
      RTI:   nxt = tms ? SELDR : RTI;
      SELDR: nxt = tms ? SELIR : CAPDR;
      CAPDR: nxt = tms ? EX1DR : SHDR;
      SHDR:  nxt = tms ? EX1DR : SHDR;
      EX1DR: nxt = tms ? UPDR  : PSDR;
      PSDR:  nxt = tms ? EX2DR : PSDR;
      EX2DR: nxt = tms ? UPDR  : SHDR;
      UPDR:  nxt = tms ? SELDR : RTI;
      SELIR: nxt = tms ? TLR   : CAPIR;
      CAPIR: nxt = tms ? EX1IR : SHIR;
      SHIR:  nxt = tms ? EX1IR : SHIR;
      EX1IR: nxt = tms ? UPIR  : PSIR;
      PSIR:  nxt = tms ? EX2IR : PSIR;
      EX2IR: nxt = tms ? UPIR  : SHIR;
      UPIR:  nxt = tms ? SELDR : RTI;
      default: nxt = TLR;
    endcase
  end

  assign grant_ok  = (ir_sr >= OP_AUX0) && (ir_sr <= OP_AUX2);
  assign grant_off = ir_sr - 5'd2;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      st     <= TLR;
      ir_q   <= OP_IDCODE;
      owner  <= 2'd0;
      paused <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt == TLR) begin
        ir_q   <= OP_IDCODE;
        owner  <= 2'd0;
        paused <= 1'b0;
      end else begin
        if (st == PSDR)
          paused <= 1'b1;
        else if (st == CAPDR)
          paused <= 1'b0;
        if (owner == 2'd0 && st == UPIR) begin
          ir_q <= ir_sr;
          if (grant_ok)
            owner <= grant_off[1:0];
        end else if (owner != 2'd0 && nxt == UPDR && paused) begin
          owner <= 2'd0;
        end
      end
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= 5'd0;
      bp_q  <= 1'b0;
      id_sr <= IDCODE_VALUE;
    end else if (owner == 2'd0) begin
      case (st)
        CAPIR: ir_sr <= OP_IDCODE;
        SHIR:  ir_sr <= {tdi, ir_sr[4:1]};
        CAPDR: begin
          bp_q  <= 1'b0;
          id_sr <= IDCODE_VALUE;
        end
        SHDR: begin
          bp_q  <= tdi;
          id_sr <= {tdi, id_sr[31:1]};
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      case (st)
        SHIR: begin
          tdo_q <= ir_sr[0];
          en_q  <= 1'b1;
        end
        SHDR: begin
          tdo_q <= (ir_q == OP_IDCODE) ? id_sr[0] : bp_q;
          en_q  <= 1'b1;
        end
        default: begin
          tdo_q <= 1'b0;
          en_q  <= 1'b0;
        end
      endcase
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_fwd
    assign aux_tms[i] = (owner == 2'(i + 1)) & tms;
    assign aux_tdi[i] = (owner == 2'(i + 1)) & tdi;
  end

  always_comb begin
    case (owner)
      2'd1:    begin tdo = aux_tdo[0]; tdo_en = aux_tdo_en[0]; end
      2'd2:    begin tdo = aux_tdo[1]; tdo_en = aux_tdo_en[1]; end
      2'd3:    begin tdo = aux_tdo[2]; tdo_en = aux_tdo_en[2]; end
      default: begin tdo = tdo_q;      tdo_en = en_q;          end
    endcase
  end

endmodule

// File: rtl/jtag_aux_tap_chk.sv
`timescale 1ns/1ps
module jtag_aux_tap_chk (
  input logic       tck,
  input logic       trst_n,
  input logic [3:0] st,
  input logic [1:0] owner,
  input logic       paused,
  input logic [4:0] ir_sr,
  input logic [4:0] ir_q,
  input logic [2:0] aux_tms,
  input logic [2:0] aux_tdi,
  input logic       tdo_en
);
  localparam logic [3:0] S_SHDR = 4'h2, S_UPDR = 4'h5, S_SHIR = 4'hA,
                         S_UPIR = 4'hD, S_TLR = 4'hF;

  a_r11_tlr_main: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_TLR) |-> (owner == 2'd0 && ir_q == 5'b00001));

  a_r7_grant: assert property (@(posedge tck) disable iff (!trst_n)
    ($past(st) == S_UPIR && $past(owner) == 2'd0 &&
     $past(ir_sr) >= 5'd3 && $past(ir_sr) <= 5'd5)
    |-> (owner == 2'($past(ir_sr) - 5'd2)));

  a_r7_quiet: assert property (@(posedge tck) disable iff (!trst_n)
    (owner == 2'd0) |-> (aux_tms == 3'b000 && aux_tdi == 3'b000));

  a_r8_single: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0(aux_tms) && $onehot0(aux_tdi));

  a_r9_return: assert property (@(posedge tck) disable iff (!trst_n)
    ($past(owner) != 2'd0 && st == S_UPDR && $past(paused)) |-> (owner == 2'd0));

  a_r9_hold: assert property (@(posedge tck) disable iff (!trst_n)
    ($past(owner) != 2'd0 && st == S_UPDR && !$past(paused)) |-> (owner == $past(owner)));

  a_r6_tdo_en: assert property (@(posedge tck) disable iff (!trst_n)
    (owner == 2'd0 && tdo_en) |-> (st == S_SHIR || st == S_SHDR));
endmodule

bind jtag_aux_tap jtag_aux_tap_chk u_chk (
  .tck(tck), .trst_n(trst_n), .st(st), .owner(owner), .paused(paused),
  .ir_sr(ir_sr), .ir_q(ir_q), .aux_tms(aux_tms), .aux_tdi(aux_tdi),
  .tdo_en(tdo_en)
);

// File: tb/tb_jtag_aux_tap.sv
`timescale 1ns/1ps
module tb_jtag_aux_tap;
  localparam logic [31:0] IDV = 32'h4B6A_D0E5;

  logic tck = 0, trst_n = 0, tms = 1, tdi = 0;
  logic tdo, tdo_en;
  logic [2:0] aux_tms, aux_tdi;
  logic [2:0] aux_tdo = 3'b000, aux_tdo_en = 3'b000;

  jtag_aux_tap #(.IDCODE_VALUE(IDV)) dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .aux_tms(aux_tms), .aux_tdi(aux_tdi), .aux_tdo(aux_tdo), .aux_tdo_en(aux_tdo_en));

  always #2 tck = ~tck;

  always @(negedge tck) begin
    aux_tdo    <= aux_tdi ^ 3'b010;
    aux_tdo_en <= aux_tms | 3'b001;
  end

  // model state names: 0 reset, 1 idle, 2..8 DR column, 9..15 IR column
  localparam int M_TLR = 0, M_RTI = 1, M_SDR = 2, M_CDR = 3, M_HDR = 4, M_E1D = 5,
                 M_PDR = 6, M_E2D = 7, M_UDR = 8, M_SIR = 9, M_CIR = 10, M_HIR = 11,
                 M_E1I = 12, M_PIR = 13, M_E2I = 14, M_UIR = 15;

  int m_st, m_owner;
  bit m_paused, m_bp;
  bit [4:0] m_ir, m_irsr;
  bit [31:0] m_id;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur = "R2";
  logic [31:0] cap;

  function automatic int nxt(int s, bit m);
    case (s)
      M_TLR: return m ? M_TLR : M_RTI;
      M_RTI: return m ? M_SDR : M_RTI;
      M_SDR: return m ? M_SIR : M_CDR;
      M_CDR: return m ? M_E1D : M_HDR;
      M_HDR: return m ? M_E1D : M_HDR;
      M_E1D: return m ? M_UDR : M_PDR;
      M_PDR: return m ? M_E2D : M_PDR;
      M_E2D: return m ? M_UDR : M_HDR;
      M_UDR: return m ? M_SDR : M_RTI;
      M_SIR: return m ? M_TLR : M_CIR;
      M_CIR: return m ? M_E1I : M_HIR;
      M_HIR: return m ? M_E1I : M_HIR;
      M_E1I: return m ? M_UIR : M_PIR;
      M_PIR: return m ? M_E2I : M_PIR;
      M_E2I: return m ? M_UIR : M_HIR;
      default: return m ? M_SDR : M_RTI;
    endcase
  endfunction

  task automatic model_reset();
    m_st = M_TLR; m_owner = 0; m_paused = 0; m_ir = 5'b00001;
    m_irsr = 0; m_bp = 0; m_id = IDV;
  endtask

  task automatic model_edge(bit m, bit d);
    int s = m_st;
    int n = nxt(s, m);
    bit old_p = m_paused;
    if (m_owner == 0) begin
      if (s == M_CIR) m_irsr = 5'b00001;
      if (s == M_HIR) m_irsr = {d, m_irsr[4:1]};
      if (s == M_CDR) begin m_bp = 0; m_id = IDV; end
      if (s == M_HDR) begin m_bp = d; m_id = {d, m_id[31:1]}; end
    end
    if (n == M_TLR) begin
      m_owner = 0; m_ir = 5'b00001; m_paused = 0;
    end else begin
      if (s == M_PDR) m_paused = 1;
      else if (s == M_CDR) m_paused = 0;
      if (s == M_UIR && m_owner == 0) begin
        m_ir = m_irsr;
        if (m_irsr >= 3 && m_irsr <= 5) m_owner = int'(m_irsr) - 2;
      end else if (m_owner != 0 && n == M_UDR && old_p) m_owner = 0;
    end
    m_st = n;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // called one ns after a rising edge; samples one ns after the falling edge
  task automatic step(bit m, bit d, output logic sampled);
    bit etdo, een;
    logic [2:0] efwd_t, efwd_d;
    tms = m; tdi = d;
    #2;
    if (m_owner == 0) begin
      een = (m_st == M_HIR || m_st == M_HDR);
      etdo = 0;
      if (m_st == M_HIR) etdo = m_irsr[0];
      if (m_st == M_HDR) etdo = (m_ir == 5'b00001) ? m_id[0] : m_bp;
      efwd_t = 3'b000; efwd_d = 3'b000;
    end else begin
      etdo = aux_tdo[m_owner-1]; een = aux_tdo_en[m_owner-1];
      efwd_t = 3'(m) << (m_owner-1); efwd_d = 3'(d) << (m_owner-1);
    end
    chk(cur, "tdo", tdo, etdo);
    chk(cur, "tdo_en", tdo_en, een);
    chk(cur, "aux_tms", aux_tms, efwd_t);
    chk(cur, "aux_tdi", aux_tdi, efwd_d);
    sampled = tdo;
    @(posedge tck); #1;
    model_edge(m, d);
  endtask

  task automatic go(bit m);
    logic s;
    step(m, 0, s);
  endtask

  task automatic shift_ir(logic [4:0] op, output logic [31:0] got);
    logic s;
    got = 0;
    go(1); go(1); go(0); go(0);
    for (int k = 0; k < 5; k++) begin
      step(k == 4, op[k], s);
      got[k] = s;
    end
    go(1); go(0);
  endtask

  task automatic shift_dr(int n, logic [31:0] data, bit pause, output logic [31:0] got);
    logic s;
    got = 0;
    go(1); go(0); go(0);
    for (int k = 0; k < n; k++) begin
      step(k == n - 1, data[k], s);
      got[k] = s;
    end
    if (pause) begin go(0); go(1); go(1); end
    else go(1);
    go(0);
  endtask

  initial begin
    model_reset();
    repeat (2) @(posedge tck);
    #1;
    chk("R2", "reset tdo_en", tdo_en, 0);
    chk("R2", "reset aux_tms", aux_tms, 0);
    chk("R2", "reset aux_tdi", aux_tdi, 0);
    trst_n = 1;
    cur = "R1"; go(0);
    cur = "R5"; shift_dr(32, 32'h0, 0, cap);
    chk("R5", "idcode read", cap, IDV);
    cur = "R3"; shift_ir(5'b11111, cap);
    chk("R3", "ir capture", cap[4:0], 5'b00001);
    cur = "R4"; shift_dr(8, 32'hA5, 0, cap);
    chk("R4", "bypass delay", cap[7:0], 8'h4A);
    cur = "R6"; shift_ir(5'b00111, cap);
    cur = "R4"; shift_dr(8, 32'h3C, 0, cap);
    chk("R4", "unused opcode bypass", cap[7:0], 8'h78);
    cur = "R7"; shift_ir(5'b00011, cap);
    cur = "R8"; go(0); step(0, 1, cap[0]); step(0, 0, cap[0]); step(0, 1, cap[0]);
    cur = "R10"; shift_ir(5'b00001, cap);
    cur = "R9"; shift_dr(6, 32'h2D, 0, cap);
    go(0);
    shift_dr(6, 32'h15, 1, cap);
    cur = "R10"; shift_dr(8, 32'hC3, 0, cap);
    chk("R10", "ir kept access opcode, bypass path", cap[7:0], 8'h86);
    cur = "R7"; shift_ir(5'b00101, cap);
    cur = "R8"; step(0, 1, cap[0]); go(0);
    cur = "R11"; go(1); go(1); go(1); go(1); go(1);
    cur = "R1"; go(0);
    cur = "R7"; shift_ir(5'b00100, cap);
    cur = "R8"; step(0, 1, cap[0]); shift_dr(4, 32'h9, 0, cap);
    cur = "R11";
    trst_n = 0; model_reset();
    @(posedge tck); #1;
    trst_n = 1;
    go(0);
    cur = "R2"; shift_dr(32, 32'h0, 0, cap);
    chk("R2", "idcode after trst", cap, IDV);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule